// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block decides what a single shared memory word receives during one write phase when several processors may target it at once. Every cycle it takes N write requests side by side. Each request is a valid bit and a data word, and its lane number serves as the processor index. A mode input selects the collision policy:

- **Exclusive:** a collision is an error.
- **Priority:** the highest lane wins.
- **Common:** all writers must agree on the value.
- **Arbitrary:** the lowest lane wins.
- **Combining:** all valid values are reduced by a selectable operator.

The outcome is registered. One cycle after the requests, the block shows a commit strobe with the value to store, or an error flag, or neither.

The surrounding memory array, the read path and the request routing are outside this block. A memory built from these resolvers places one instance at each location, or time-shares one instance across locations. It writes `wr_data` into the word whenever `wr_commit` is high.

Top module: `cw_resolver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wr_commit`, `wr_err` and `wr_data` are all zero.
- R2: Outputs reflect the requests of the previous cycle. When no request was valid, `wr_commit` and `wr_err` are low.
- R3: When exactly one request is valid and `mode` is 0 to 4, that request's data is committed with no error, whatever the combining operator.
- R4: In mode 0 (exclusive), two or more valid requests raise `wr_err` and commit nothing.
- R5: In mode 1 (priority), with two or more valid requests, the data of the valid request with the highest lane index is committed.
- R6: In mode 2 (common), with two or more valid requests, the value is committed if all valid data are equal. If any valid data differ, `wr_err` is raised and nothing is committed.
- R7: In mode 3 (arbitrary), with two or more valid requests, the data of the valid request with the lowest lane index is committed.
- R8: In mode 4 (combining), with two or more valid requests, the committed value is the reduction of the valid data only. The `op` field selects the operator: 0 sum modulo 2^W, 1 unsigned maximum, 2 unsigned minimum, 3 bitwise AND, 4 bitwise OR, 5 bitwise XOR.
- R9: In mode 4, when `op` is 6 or 7 and two or more requests are valid, `wr_err` is raised and nothing is committed.
- R10: When `mode` is 5, 6 or 7 and at least one request is valid, `wr_err` is raised and nothing is committed.
- R11: `wr_commit` and `wr_err` are never high together, and `wr_data` is zero whenever `wr_commit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Per-lane write request valid; bit i is lane i |
| req_data | input | N*W | Per-lane write data; lane i at bits [i*W +: W] |
| mode | input | 3 | Collision policy: 0 exclusive, 1 priority, 2 common, 3 arbitrary, 4 combining |
| op | input | 3 | Combining operator: 0 sum, 1 max, 2 min, 3 and, 4 or, 5 xor |
| wr_commit | output | 1 | Registered strobe: store `wr_data` this cycle |
| wr_data | output | W | Registered value to store |
| wr_err | output | 1 | Registered flag for an illegal or failed collision |

## Verification
The bench builds the block with N = 5 and W = 8. Five lanes is not a power of two, so the lane scans and the reduction tree must handle a ragged top lane. They also give room for three-way and four-way collisions with the valid lanes split apart. The 8-bit width lets a sum of two lanes wrap, and it lets unsigned comparisons meet operands with the top bit set. Directed cases cover each mode and each operator. A randomized run follows, which compares the outputs with a behavioural model on every clock.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

    typedef enum logic [2:0] {
        MODE_EXCL    = 3'd0,
        MODE_PRIO    = 3'd1,
        MODE_COMMON  = 3'd2,
        MODE_ANY     = 3'd3,
        MODE_COMBINE = 3'd4
    } cw_mode_e;

    typedef enum logic [2:0] {
        OP_SUM = 3'd0,
        OP_MAX = 3'd1,
        OP_MIN = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5
    } cw_op_e;

    // How many lanes requested in a cycle
    typedef struct packed {
        logic none;
        logic single;
        logic multi;
    } occ_t;

    function automatic logic mode_known(input logic [2:0] m);
        return m <= 3'd4;
    endfunction

    function automatic logic op_known(input logic [2:0] o);
        return o <= 3'd5;
    endfunction

endpackage

// File: rtl/cwr_scan.sv
module cwr_scan
    import cwr_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   valid,
    input  logic [N*W-1:0] data,
    output occ_t           occ,
    output logic [W-1:0]   lo_data,
    output logic [W-1:0]   hi_data
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(valid[i]);
        end
    end

    assign occ.none   = (cnt == '0);
    assign occ.single = (cnt == CW'(1));
    assign occ.multi  = (cnt > CW'(1));

    // Lowest valid lane: scan downward so the last hit is the smallest index
    always_comb begin
        lo_data = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i]) lo_data = data[i*W +: W];
        end
    end

    // Highest valid lane: scan upward so the last hit is the largest index
    always_comb begin
        hi_data = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i]) hi_data = data[i*W +: W];
        end
    end

endmodule

// File: rtl/cwr_agree.sv
module cwr_agree #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   valid,
    input  logic [N*W-1:0] data,
    input  logic [W-1:0]   ref_data,
    output logic           all_same
);
    logic [N-1:0] mism;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign mism[g] = valid[g] && (data[g*W +: W] != ref_data);
    end

    assign all_same = ~|mism;

endmodule

// File: rtl/cwr_reduce.sv
module cwr_reduce
    import cwr_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N-1:0]   valid,
    input  logic [N*W-1:0] data,
    input  logic [2:0]     op,
    output logic [W-1:0]   result
);
    // Invalid lanes present each operator's identity element
    logic [W-1:0] r_sum, r_max, r_min, r_and, r_or, r_xor;

    always_comb begin
        r_sum = '0;
        r_max = '0;
        r_min = '1;
        r_and = '1;
        r_or  = '0;
        r_xor = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i]) begin
                r_sum = r_sum + data[i*W +: W];
                if (data[i*W +: W] > r_max) r_max = data[i*W +: W];
                if (data[i*W +: W] < r_min) r_min = data[i*W +: W];
                r_and = r_and & data[i*W +: W];
                r_or  = r_or  | data[i*W +: W];
                r_xor = r_xor ^ data[i*W +: W];
            end
        end
    end

    always_comb begin
        case (op)
            OP_SUM:  result = r_sum;
            OP_MAX:  result = r_max;
            OP_MIN:  result = r_min;
            OP_AND:  result = r_and;
            OP_OR:   result = r_or;
            OP_XOR:  result = r_xor;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/cw_resolver.sv
module cw_resolver
    import cwr_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req_valid,
    input  logic [N*W-1:0] req_data,
    input  logic [2:0]     mode,
    input  logic [2:0]     op,
    output logic           wr_commit,
    output logic [W-1:0]   wr_data,
    output logic           wr_err
);
    occ_t         occ;
    logic [W-1:0] lo_data, hi_data, red_data;
    logic         same;

    logic         nx_commit, nx_err;
    logic [W-1:0] nx_data;

    cwr_scan #(.N(N), .W(W)) u_scan (
        .valid   (req_valid),
        .data    (req_data),
        .occ     (occ),
        .lo_data (lo_data),
        .hi_data (hi_data)
    );

    cwr_agree #(.N(N), .W(W)) u_agree (
        .valid    (req_valid),
        .data     (req_data),
        .ref_data (lo_data),
        .all_same (same)
    );

    cwr_reduce #(.N(N), .W(W)) u_reduce (
        .valid  (req_valid),
        .data   (req_data),
        .op     (op),
        .result (red_data)
    );

    always_comb begin
        nx_commit = 1'b0;
        nx_err    = 1'b0;
        nx_data   = '0;
        if (!occ.none) begin
            if (!mode_known(mode)) begin
                nx_err = 1'b1;
            end else if (occ.single) begin
                nx_commit = 1'b1;
                nx_data   = lo_data;
            end else begin
                case (cw_mode_e'(mode))
                    MODE_EXCL: nx_err = 1'b1;
                    MODE_PRIO: begin
                        nx_commit = 1'b1;
                        nx_data   = hi_data;
                    end
                    MODE_COMMON: begin
                        nx_commit = same;
                        nx_err    = !same;
                        nx_data   = same ? lo_data : '0;
                    end
                    MODE_ANY: begin
                        nx_commit = 1'b1;
                        nx_data   = lo_data;
                    end
                    MODE_COMBINE: begin
                        nx_commit = op_known(op);
                        nx_err    = !op_known(op);
                        nx_data   = op_known(op) ? red_data : '0;
                    end
                    default: nx_err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_commit <= 1'b0;
            wr_err    <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_commit <= nx_commit;
            wr_err    <= nx_err;
            wr_data   <= nx_data;
        end
    end

endmodule

// File: rtl/cwr_checker.sv
module cwr_checker #(
    parameter int N = 4,
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   req_valid,
    input logic [2:0]     mode,
    input logic [2:0]     op,
    input logic           wr_commit,
    input logic [W-1:0]   wr_data,
    input logic           wr_err
);
    // Set once a full non-reset cycle has been sampled, so $past sees real requests
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!wr_commit && !wr_err && wr_data == '0));

    // R2
    idle_no_output_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(req_valid) == '0) |-> (!wr_commit && !wr_err));

    // R3
    single_commits_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($countones($past(req_valid)) == 1 && $past(mode) <= 3'd4) |-> (wr_commit && !wr_err));

    // R4
    excl_collision_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($countones($past(req_valid)) > 1 && $past(mode) == 3'd0) |-> (wr_err && !wr_commit));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($countones($past(req_valid)) > 1 && $past(mode) == 3'd4 && $past(op) > 3'd5)
            |-> (wr_err && !wr_commit));

    // R10
    bad_mode_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(req_valid) != '0 && $past(mode) > 3'd4) |-> (wr_err && !wr_commit));

    // R11
    commit_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_commit && wr_err));

    // R11
    data_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_commit |-> (wr_data == '0));

endmodule

bind cw_resolver cwr_checker #(.N(N), .W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .mode      (mode),
    .op        (op),
    .wr_commit (wr_commit),
    .wr_data   (wr_data),
    .wr_err    (wr_err)
);

// File: tb/tb_cw_resolver.sv
module tb_cw_resolver;
    localparam int N = 5;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   req_valid = '0;
    logic [N*W-1:0] req_data = '0;
    logic [2:0]     mode = '0;
    logic [2:0]     op = '0;
    logic           wr_commit;
    logic [W-1:0]   wr_data;
    logic           wr_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cw_resolver #(.N(N), .W(W)) dut (
        .clk, .rst, .req_valid, .req_data, .mode, .op,
        .wr_commit, .wr_data, .wr_err
    );

    // Behavioural model; returns {commit, err, data}
    function automatic logic [W+1:0] model(input logic [N-1:0] v, input logic [N*W-1:0] d,
                                           input logic [2:0] m, input logic [2:0] o);
        int vals[$];
        int acc;
        logic c, e;
        logic [W-1:0] r;
        c = 0; e = 0; r = '0;
        for (int i = 0; i < N; i++) if (v[i]) vals.push_back(int'(d[i*W +: W]));
        if (vals.size() == 0) return '0;
        if (m > 3'd4) return {1'b0, 1'b1, {W{1'b0}}};
        if (vals.size() == 1) return {1'b1, 1'b0, W'(vals[0])};
        case (m)
            3'd0: e = 1;
            3'd1: begin c = 1; r = W'(vals[vals.size()-1]); end
            3'd2: begin
                c = 1;
                foreach (vals[k]) if (vals[k] != vals[0]) c = 0;
                e = !c;
                r = c ? W'(vals[0]) : '0;
            end
            3'd3: begin c = 1; r = W'(vals[0]); end
            default: begin
                if (o > 3'd5) e = 1;
                else begin
                    c = 1;
                    acc = vals[0];
                    for (int k = 1; k < vals.size(); k++) begin
                        case (o)
                            3'd0: acc = (acc + vals[k]) % (1 << W);
                            3'd1: acc = (vals[k] > acc) ? vals[k] : acc;
                            3'd2: acc = (vals[k] < acc) ? vals[k] : acc;
                            3'd3: acc = acc & vals[k];
                            3'd4: acc = acc | vals[k];
                            default: acc = acc ^ vals[k];
                        endcase
                    end
                    r = W'(acc);
                end
            end
        endcase
        return {c, e, r};
    endfunction

    task automatic compare(input logic [W+1:0] exp, input string tag);
        checks++;
        if ({wr_commit, wr_err, wr_data} !== exp) begin
            fails++;
            $display("FAIL %s: got commit=%0b err=%0b data=%0h, expected commit=%0b err=%0b data=%0h",
                     tag, wr_commit, wr_err, wr_data, exp[W+1], exp[W], exp[W-1:0]);
        end
    endtask

    // Drive at a falling edge; the result is registered at the next rising edge
    task automatic apply(input logic [N-1:0] v, input logic [N*W-1:0] d,
                         input logic [2:0] m, input logic [2:0] o, input string tag);
        logic [W+1:0] exp;
        req_valid = v; req_data = d; mode = m; op = o;
        exp = model(v, d, m, o);
        @(negedge clk);
        compare(exp, tag);
    endtask

    function automatic logic [N*W-1:0] pack(input int a0, input int a1, input int a2,
                                            input int a3, input int a4);
        return {W'(a4), W'(a3), W'(a2), W'(a1), W'(a0)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        req_valid = '1;
        req_data  = pack(1, 2, 3, 4, 5);
        mode      = 3'd1;
        @(negedge clk);
        compare('0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        req_valid = '0;
        compare('0, "R1 held after reset");

        apply('0, pack(9, 9, 9, 9, 9), 3'd3, 3'd0, "R2 idle");
        for (int m = 0; m < 5; m++)
            apply(5'b00100, pack(0, 0, 8'hA7, 0, 0), 3'(m), 3'd7, "R3 single lane");
        apply(5'b10000, pack(0, 0, 0, 0, 8'h3C), 3'd4, 3'd6, "R3 single in combining bad op");
        apply(5'b01010, pack(1, 2, 3, 4, 5), 3'd0, 3'd0, "R4 exclusive collision");
        apply(5'b10101, pack(8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 3'd1, 3'd0, "R5 priority");
        apply(5'b00111, pack(8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 3'd1, 3'd0, "R5 priority mid");
        apply(5'b11001, pack(8'h6E, 8'h01, 8'h02, 8'h6E, 8'h6E), 3'd2, 3'd0, "R6 common agree");
        apply(5'b11001, pack(8'h6E, 8'h01, 8'h02, 8'h6E, 8'h6F), 3'd2, 3'd0, "R6 common differ");
        apply(5'b01010, pack(8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 3'd3, 3'd0, "R7 arbitrary");
        apply(5'b00011, pack(200, 100, 7, 7, 7), 3'd4, 3'd0, "R8 sum wraps");
        apply(5'b10110, pack(8'hFF, 8'h80, 8'h7F, 0, 8'h90), 3'd4, 3'd1, "R8 max unsigned");
        apply(5'b10110, pack(0, 8'h80, 8'h7F, 0, 8'h90), 3'd4, 3'd2, "R8 min unsigned");
        apply(5'b01110, pack(0, 8'hF3, 8'h3F, 8'h7B, 0), 3'd4, 3'd3, "R8 and");
        apply(5'b10001, pack(8'h01, 8'hFF, 8'hFF, 8'hFF, 8'h80), 3'd4, 3'd4, "R8 or");
        apply(5'b11111, pack(8'h01, 8'h02, 8'h04, 8'h08, 8'h18), 3'd4, 3'd5, "R8 xor");
        apply(5'b00011, pack(1, 2, 0, 0, 0), 3'd4, 3'd7, "R9 bad operator");
        apply(5'b00001, pack(1, 0, 0, 0, 0), 3'd6, 3'd0, "R10 bad mode");
        apply(5'b00000, pack(1, 0, 0, 0, 0), 3'd7, 3'd0, "R10 bad mode idle");

        for (int k = 0; k < 400; k++) begin
            logic [N*W-1:0] d;
            d = {$urandom, $urandom};
            if (k % 3 == 0) d = {N{d[W-1:0]}};
            apply(N'($urandom), d, 3'($urandom % 6), 3'($urandom % 8), "R11 random vs model");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule